// File: doc/BRIEF.md
# Migration Placement Controller

This block is the per-tile sequencer that carries out a line migration once a destination tile has been chosen. When a migrating line (called B below) is offered to the target set, the controller picks one of three placements: it drops B into a free way, it trades places with the least-recently-used line of the set (called D below), or it throws D away and puts B in its way. Before it moves anything, it asks the migration tables for the bookkeeping entries the move needs. Those tables can refuse, so the same trigger can end in several ways. The result is reported as a one-cycle outcome code.

After B has been placed, the tile keeps B's previous copy live until the destination confirms that B has arrived. Any lookup that lands during this window is served from that copy, and the requesting tile is remembered. On arrival the copy is released, and the set of remembered requesters is pushed to the new host so it can merge them into B's sharer state. Only one migration is in flight per tile. A new trigger is held off until the controller is idle again.

Top module: `mig_place_ctrl`

## Requirements
- R1: After reset `trig_ready` is high and every strobe is low. `trig_ready` is high only while idle: it drops in the cycle after a trigger is taken and stays low until that migration resolves. A trigger offered while `trig_ready` is low produces no command and no outcome.
- R2: When B has never left its home (`b_migr`=0), the first action is a one-cycle `tbl_req_b_home` pulse one clock after the trigger. No move command is issued before the response.
- R3: A denial at B's home yields outcome code 3 (cancelled) one clock later, with no move command, and the controller returns to idle.
- R4: When the target set has a free way, the controller issues `cmd_place` with `cmd_way` equal to the free way and outcome code 0 (placed). No table request is made for D.
- R5: With no free way and D already migrated (`d_migr`=1), the controller issues `cmd_swap` at the LRU way together with `upd_d_entries`, and outcome code 1 (swapped).
- R6: With no free way and D not migrated, the controller pulses `tbl_req_d_home`. A grant gives `cmd_swap` at the LRU way with outcome 1 and no `upd_d_entries`. A denial gives `cmd_discard` at the LRU way with outcome 2 (victim discarded).
- R7: `upd_b_entries` pulses together with the move command exactly when B was already migrated at trigger time. It never pulses for a B that is still at home.
- R8: From the move command until `arr_ack`, each `xit_req_valid` is answered by `xit_serve` in the same cycle. Outside that window `xit_serve` stays low.
- R9: One clock after `arr_ack`, `copy_drop` and `sharer_push` pulse. At that point bit i of `sharer_vec` is set exactly when tile i was served during the window, including a request in the `arr_ack` cycle itself. The next window starts empty.
- R10: Command and outcome strobes last one cycle, and at most one of `cmd_place`, `cmd_swap` and `cmd_discard` is high at a time.
- R11: The set status captured at the trigger is used for the whole migration. Later changes on those inputs have no effect. If grant and deny arrive together, the grant wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | Migration of B into this set requested |
| trig_ready | output | 1 | Controller idle, trigger accepted |
| set_has_free | input | 1 | Target set holds an invalid way |
| free_way | input | WAY_W | Index of the invalid way |
| lru_way | input | WAY_W | Index of the LRU line D |
| b_migr | input | 1 | B has already left its home |
| d_migr | input | 1 | D has already left its home |
| tbl_req_b_home | output | 1 | Request a local entry in B's home table |
| tbl_req_d_home | output | 1 | Request a local entry in D's home table |
| tbl_grant | input | 1 | Outstanding table request granted |
| tbl_deny | input | 1 | Outstanding table request refused |
| cmd_place | output | 1 | Write B into `cmd_way`, nothing displaced |
| cmd_swap | output | 1 | Exchange B with the line in `cmd_way` |
| cmd_discard | output | 1 | Drop the line in `cmd_way`, write B there |
| cmd_way | output | WAY_W | Way addressed by the move command |
| upd_b_entries | output | 1 | Refresh all of B's table entries with the new host |
| upd_d_entries | output | 1 | Refresh all of D's table entries with the new host |
| out_valid | output | 1 | Outcome strobe |
| out_code | output | 2 | 0 placed, 1 swapped, 2 discarded, 3 cancelled |
| xit_req_valid | input | 1 | Lookup for B arriving at the old copy |
| xit_req_id | input | TID_W | Requesting tile of that lookup |
| xit_serve | output | 1 | Lookup served from the old copy |
| arr_ack | input | 1 | New host confirms B's arrival |
| copy_drop | output | 1 | Release the old copy of B |
| sharer_push | output | 1 | Send `sharer_vec` to the new host |
| sharer_vec | output | NTILE | Tiles served during the transit window |

## Verification
The placement decision is exercised with four target-set patterns: a free way, a migrated victim, and an unmigrated victim whose home table grants and then denies. Together these separate the place, swap and discard paths and show whether the victim's update strobe is tied to the right one. The home request for B is tried with both a stay-at-home B and an already-migrated B, and with a denial that must cancel. These runs show whether the table handshake gates the move and whether B's update follows its history. The transit window gets lookups from two tiles, one of them in the acknowledge cycle, plus a lookup outside the window. Triggers and set-status changes are also applied while the controller is busy, to confirm both the capture at the trigger and the back-pressure.

// File: rtl/mig_pkg.sv
package mig_pkg;

   typedef enum logic [1:0] {
      OC_PLACED  = 2'd0,
      OC_SWAPPED = 2'd1,
      OC_DISCARD = 2'd2,
      OC_CANCEL  = 2'd3
   } mig_outc_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT_B = 2'd1,
      ST_WAIT_D = 2'd2,
      ST_XIT    = 2'd3
   } mig_state_e;

endpackage

// File: rtl/mig_xit_tracker.sv
module mig_xit_tracker #(
   parameter int NTILE = 16,
   parameter int TID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rec_en,
   input  logic [TID_W-1:0] rec_id,
   input  logic             clr,
   output logic [NTILE-1:0] vec_next
);

   logic [NTILE-1:0] vec_q;

   for (genvar g = 0; g < NTILE; g++) begin : g_bit
      logic hit;
      assign hit         = rec_en && (rec_id == TID_W'(g));
      assign vec_next[g] = vec_q[g] | hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     vec_q[g] <= 1'b0;
         else if (clr)   vec_q[g] <= 1'b0;
         else if (hit)   vec_q[g] <= 1'b1;
      end
   end

endmodule

// File: rtl/mig_place_fsm.sv
module mig_place_fsm
   import mig_pkg::*;
#(
   parameter int WAY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_valid,
   input  logic             set_has_free,
   input  logic [WAY_W-1:0] free_way,
   input  logic [WAY_W-1:0] lru_way,
   input  logic             b_migr,
   input  logic             d_migr,
   input  logic             tbl_grant,
   input  logic             tbl_deny,
   input  logic             arr_ack,
   output logic             idle,
   output logic             in_xit,
   output logic             req_b,
   output logic             req_d,
   output logic             place,
   output logic             swap,
   output logic             discard,
   output logic [WAY_W-1:0] way,
   output logic             upd_b,
   output logic             upd_d,
   output logic             out_v,
   output mig_outc_e        out_c,
   output logic             drop
);

   mig_state_e state, n_state;

   // context captured at trigger
   logic             r_free, r_bm, r_dm;
   logic [WAY_W-1:0] r_fw, r_lw;
   logic             c_free, c_bm, c_dm;
   logic [WAY_W-1:0] c_fw, c_lw;

   logic             p_req_b, p_req_d, p_place, p_swap, p_disc;
   logic             p_updb, p_updd, p_out, p_drop, decide;
   logic [WAY_W-1:0] p_way;
   mig_outc_e        p_code;

   assign idle   = (state == ST_IDLE);
   assign in_xit = (state == ST_XIT);

   assign c_free = idle ? set_has_free : r_free;
   assign c_bm   = idle ? b_migr       : r_bm;
   assign c_dm   = idle ? d_migr       : r_dm;
   assign c_fw   = idle ? free_way     : r_fw;
   assign c_lw   = idle ? lru_way      : r_lw;

   always_comb begin
      n_state = state;
      p_req_b = 1'b0;
      p_req_d = 1'b0;
      p_place = 1'b0;
      p_swap  = 1'b0;
      p_disc  = 1'b0;
      p_updb  = 1'b0;
      p_updd  = 1'b0;
      p_out   = 1'b0;
      p_drop  = 1'b0;
      p_code  = OC_PLACED;
      p_way   = c_free ? c_fw : c_lw;
      decide  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (trig_valid) begin
               if (!b_migr) begin
                  p_req_b = 1'b1;
                  n_state = ST_WAIT_B;
               end else begin
                  decide = 1'b1;
               end
            end
         end
         ST_WAIT_B: begin
            if (tbl_grant) begin
               decide = 1'b1;
            end else if (tbl_deny) begin
               p_out   = 1'b1;
               p_code  = OC_CANCEL;
               n_state = ST_IDLE;
            end
         end
         ST_WAIT_D: begin
            if (tbl_grant) begin
               p_swap  = 1'b1;
               p_updb  = c_bm;
               p_out   = 1'b1;
               p_code  = OC_SWAPPED;
               n_state = ST_XIT;
            end else if (tbl_deny) begin
               p_disc  = 1'b1;
               p_updb  = c_bm;
               p_out   = 1'b1;
               p_code  = OC_DISCARD;
               n_state = ST_XIT;
            end
         end
         ST_XIT: begin
            if (arr_ack) begin
               p_drop  = 1'b1;
               n_state = ST_IDLE;
            end
         end
         default: n_state = ST_IDLE;
      endcase

      if (decide) begin
         if (c_free) begin
            p_place = 1'b1;
            p_updb  = c_bm;
            p_out   = 1'b1;
            p_code  = OC_PLACED;
            n_state = ST_XIT;
         end else if (c_dm) begin
            p_swap  = 1'b1;
            p_updb  = c_bm;
            p_updd  = 1'b1;
            p_out   = 1'b1;
            p_code  = OC_SWAPPED;
            n_state = ST_XIT;
         end else begin
            p_req_d = 1'b1;
            n_state = ST_WAIT_D;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_free  <= 1'b0;
         r_bm    <= 1'b0;
         r_dm    <= 1'b0;
         r_fw    <= '0;
         r_lw    <= '0;
         req_b   <= 1'b0;
         req_d   <= 1'b0;
         place   <= 1'b0;
         swap    <= 1'b0;
         discard <= 1'b0;
         way     <= '0;
         upd_b   <= 1'b0;
         upd_d   <= 1'b0;
         out_v   <= 1'b0;
         out_c   <= OC_PLACED;
         drop    <= 1'b0;
      end else begin
         state   <= n_state;
         if (idle && trig_valid) begin
            r_free <= set_has_free;
            r_bm   <= b_migr;
            r_dm   <= d_migr;
            r_fw   <= free_way;
            r_lw   <= lru_way;
         end
         req_b   <= p_req_b;
         req_d   <= p_req_d;
         place   <= p_place;
         swap    <= p_swap;
         discard <= p_disc;
         if (p_place || p_swap || p_disc) way <= p_way;
         upd_b   <= p_updb;
         upd_d   <= p_updd;
         out_v   <= p_out;
         out_c   <= p_code;
         drop    <= p_drop;
      end
   end

endmodule

// File: rtl/mig_place_ctrl.sv
module mig_place_ctrl
   import mig_pkg::*;
#(
   parameter  int WAYS  = 16,
   parameter  int NTILE = 16,
   localparam int WAY_W = $clog2(WAYS),
   localparam int TID_W = $clog2(NTILE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_valid,
   output logic             trig_ready,
   input  logic             set_has_free,
   input  logic [WAY_W-1:0] free_way,
   input  logic [WAY_W-1:0] lru_way,
   input  logic             b_migr,
   input  logic             d_migr,
   output logic             tbl_req_b_home,
   output logic             tbl_req_d_home,
   input  logic             tbl_grant,
   input  logic             tbl_deny,
   output logic             cmd_place,
   output logic             cmd_swap,
   output logic             cmd_discard,
   output logic [WAY_W-1:0] cmd_way,
   output logic             upd_b_entries,
   output logic             upd_d_entries,
   output logic             out_valid,
   output logic [1:0]       out_code,
   input  logic             xit_req_valid,
   input  logic [TID_W-1:0] xit_req_id,
   output logic             xit_serve,
   input  logic             arr_ack,
   output logic             copy_drop,
   output logic             sharer_push,
   output logic [NTILE-1:0] sharer_vec
);

   if (WAYS < 2) begin : g_bad_ways
      $error("mig_place_ctrl: WAYS must be at least 2");
   end
   if (NTILE < 2) begin : g_bad_tiles
      $error("mig_place_ctrl: NTILE must be at least 2");
   end

   logic             in_xit, f_drop;
   mig_outc_e        f_code;
   logic [NTILE-1:0] vec_next;
   logic [NTILE-1:0] vec_q;

   mig_place_fsm #(.WAY_W(WAY_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_valid   (trig_valid),
      .set_has_free (set_has_free),
      .free_way     (free_way),
      .lru_way      (lru_way),
      .b_migr       (b_migr),
      .d_migr       (d_migr),
      .tbl_grant    (tbl_grant),
      .tbl_deny     (tbl_deny),
      .arr_ack      (arr_ack),
      .idle         (trig_ready),
      .in_xit       (in_xit),
      .req_b        (tbl_req_b_home),
      .req_d        (tbl_req_d_home),
      .place        (cmd_place),
      .swap         (cmd_swap),
      .discard      (cmd_discard),
      .way          (cmd_way),
      .upd_b        (upd_b_entries),
      .upd_d        (upd_d_entries),
      .out_v        (out_valid),
      .out_c        (f_code),
      .drop         (f_drop)
   );

   assign out_code  = f_code;
   assign xit_serve = xit_req_valid && in_xit;

   mig_xit_tracker #(.NTILE(NTILE), .TID_W(TID_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_en   (xit_serve),
      .rec_id   (xit_req_id),
      .clr      (in_xit && arr_ack),
      .vec_next (vec_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  vec_q <= '0;
      else if (in_xit && arr_ack)  vec_q <= vec_next;
   end

   assign copy_drop   = f_drop;
   assign sharer_push = f_drop;
   assign sharer_vec  = vec_q;

endmodule

// File: rtl/mig_place_chk.sv
module mig_place_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       trig_valid,
   input logic       trig_ready,
   input logic       tbl_req_b_home,
   input logic       tbl_req_d_home,
   input logic       cmd_place,
   input logic       cmd_swap,
   input logic       cmd_discard,
   input logic       upd_b_entries,
   input logic       upd_d_entries,
   input logic       out_valid,
   input logic [1:0] out_code,
   input logic       xit_req_valid,
   input logic       xit_serve,
   input logic       copy_drop,
   input logic       sharer_push
);

   logic any_cmd;
   assign any_cmd = cmd_place | cmd_swap | cmd_discard;

   // R1: accepted trigger closes the door in the next cycle
   a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_valid && trig_ready) |=> !trig_ready);

   // R2: home request comes before any move and leaves the controller busy
   a_r2_req_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_req_b_home |-> (!any_cmd && !trig_ready));

   // R3: cancellation moves nothing
   a_r3_cancel_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_code == 2'd3) |-> !any_cmd);

   // R5: victim refresh only on a swap
   a_r5_updd_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
      upd_d_entries |-> cmd_swap);

   // R6: D request never coincides with a move
   a_r6_reqd_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_req_d_home |-> !any_cmd);

   // R7: B refresh rides on a move command
   a_r7_updb_on_move: assert property (@(posedge clk) disable iff (!rst_n)
      upd_b_entries |-> any_cmd);

   // R8: a served lookup needs a request and a busy controller
   a_r8_serve_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      xit_serve |-> (xit_req_valid && !trig_ready));

   // R9: release and sharer push travel together
   a_r9_drop_push: assert property (@(posedge clk) disable iff (!rst_n)
      copy_drop |-> sharer_push);

   // R10: single move command, single-cycle strobes
   a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cmd_place, cmd_swap, cmd_discard}) <= 1);
   a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |=> !any_cmd);
   a_r10_cmd_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |-> out_valid);

endmodule

bind mig_place_ctrl mig_place_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .trig_valid     (trig_valid),
   .trig_ready     (trig_ready),
   .tbl_req_b_home (tbl_req_b_home),
   .tbl_req_d_home (tbl_req_d_home),
   .cmd_place      (cmd_place),
   .cmd_swap       (cmd_swap),
   .cmd_discard    (cmd_discard),
   .upd_b_entries  (upd_b_entries),
   .upd_d_entries  (upd_d_entries),
   .out_valid      (out_valid),
   .out_code       (out_code),
   .xit_req_valid  (xit_req_valid),
   .xit_serve      (xit_serve),
   .copy_drop      (copy_drop),
   .sharer_push    (sharer_push)
);

// File: tb/sim_mig_place_ctrl.sv
module sim_mig_place_ctrl;

   localparam int CLK_P = 10;
   localparam int WAYS  = 16;
   localparam int NTILE = 16;
   localparam int WAY_W = $clog2(WAYS);
   localparam int TID_W = $clog2(NTILE);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_valid, set_has_free, b_migr, d_migr;
   logic [WAY_W-1:0] free_way, lru_way, cmd_way;
   logic trig_ready, tbl_req_b_home, tbl_req_d_home, tbl_grant, tbl_deny;
   logic cmd_place, cmd_swap, cmd_discard, upd_b_entries, upd_d_entries;
   logic out_valid;
   logic [1:0] out_code;
   logic xit_req_valid, xit_serve, arr_ack, copy_drop, sharer_push;
   logic [TID_W-1:0] xit_req_id;
   logic [NTILE-1:0] sharer_vec;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   mig_place_ctrl #(.WAYS(WAYS), .NTILE(NTILE)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
      .set_has_free(set_has_free), .free_way(free_way), .lru_way(lru_way),
      .b_migr(b_migr), .d_migr(d_migr), .tbl_req_b_home(tbl_req_b_home),
      .tbl_req_d_home(tbl_req_d_home), .tbl_grant(tbl_grant), .tbl_deny(tbl_deny),
      .cmd_place(cmd_place), .cmd_swap(cmd_swap), .cmd_discard(cmd_discard),
      .cmd_way(cmd_way), .upd_b_entries(upd_b_entries), .upd_d_entries(upd_d_entries),
      .out_valid(out_valid), .out_code(out_code), .xit_req_valid(xit_req_valid),
      .xit_req_id(xit_req_id), .xit_serve(xit_serve), .arr_ack(arr_ack),
      .copy_drop(copy_drop), .sharer_push(sharer_push), .sharer_vec(sharer_vec)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic quiet();
      trig_valid = 0; set_has_free = 0; free_way = '0; lru_way = '0;
      b_migr = 0; d_migr = 0; tbl_grant = 0; tbl_deny = 0;
      xit_req_valid = 0; xit_req_id = '0; arr_ack = 0;
   endtask

   // edge then sample just after it
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic fire(input logic fr, input int fw, input int lw, input logic bm, input logic dm);
      @(negedge clk);
      trig_valid = 1; set_has_free = fr; free_way = WAY_W'(fw); lru_way = WAY_W'(lw);
      b_migr = bm; d_migr = dm;
      step();
      @(negedge clk);
      trig_valid = 0;
   endtask

   task automatic close_window(input string tag, input logic [NTILE-1:0] exp_vec);
      arr_ack = 1;
      step();
      chk({tag, " R9 copy_drop"}, 32'(copy_drop), 1);
      chk({tag, " R9 sharer_push"}, 32'(sharer_push), 1);
      chk({tag, " R9 sharer_vec"}, 32'(sharer_vec), 32'(exp_vec));
      chk({tag, " R1 ready again"}, 32'(trig_ready), 1);
      @(negedge clk); quiet();
      step();
      chk({tag, " R10 drop pulse"}, 32'(copy_drop), 0);
   endtask

   task automatic t_reset();
      chk("R1 reset ready", 32'(trig_ready), 1);
      chk("R1 reset strobes", 32'({cmd_place, cmd_swap, cmd_discard, out_valid,
          tbl_req_b_home, tbl_req_d_home, copy_drop, upd_b_entries}), 0);
   endtask

   task automatic t_free_way();
      fire(1, 5, 1, 1, 0);
      chk("R4 place", 32'(cmd_place), 1);
      chk("R4 way", 32'(cmd_way), 5);
      chk("R4 code placed", 32'({out_valid, out_code}), 32'h4);
      chk("R4 no D req", 32'(tbl_req_d_home), 0);
      chk("R7 updb migrated B", 32'(upd_b_entries), 1);
      chk("R1 busy", 32'(trig_ready), 0);
      // busy trigger plus lookup from tile 3
      trig_valid = 1; set_has_free = 1; free_way = 6; b_migr = 1;
      xit_req_valid = 1; xit_req_id = 3;
      #1 chk("R8 serve in window", 32'(xit_serve), 1);
      step();
      chk("R1 busy trigger ignored", 32'({cmd_place, out_valid}), 0);
      chk("R10 place pulse", 32'(cmd_place), 0);
      @(negedge clk);
      trig_valid = 0; xit_req_id = 7;
      close_window("free", 16'h0088);
   endtask

   task automatic t_home_deny();
      fire(1, 2, 3, 0, 0);
      chk("R2 req b", 32'(tbl_req_b_home), 1);
      chk("R2 no move yet", 32'({cmd_place, cmd_swap, cmd_discard}), 0);
      xit_req_valid = 1; xit_req_id = 4;
      #1 chk("R8 no serve outside window", 32'(xit_serve), 0);
      step();
      chk("R2 req pulse", 32'(tbl_req_b_home), 0);
      @(negedge clk); xit_req_valid = 0; tbl_deny = 1;
      step();
      chk("R3 cancel code", 32'({out_valid, out_code}), 32'h7);
      chk("R3 no move", 32'({cmd_place, cmd_swap, cmd_discard}), 0);
      chk("R7 no updb", 32'(upd_b_entries), 0);
      @(negedge clk); quiet();
      step();
      chk("R3 idle", 32'(trig_ready), 1);
      chk("R10 out pulse", 32'(out_valid), 0);
   endtask

   task automatic t_migr_victim();
      fire(0, 0, 9, 0, 1);
      chk("R2 req b first", 32'(tbl_req_b_home), 1);
      lru_way = 4; set_has_free = 1; free_way = 1; tbl_grant = 1;
      step();
      chk("R5 swap", 32'(cmd_swap), 1);
      chk("R11 captured way", 32'(cmd_way), 9);
      chk("R5 upd d", 32'(upd_d_entries), 1);
      chk("R7 no updb home B", 32'(upd_b_entries), 0);
      chk("R5 code swapped", 32'({out_valid, out_code}), 32'h5);
      @(negedge clk); quiet();
      close_window("victim", '0);
   endtask

   task automatic t_unmigr_deny();
      fire(0, 0, 2, 1, 0);
      chk("R6 req d", 32'(tbl_req_d_home), 1);
      chk("R6 no req b", 32'(tbl_req_b_home), 0);
      chk("R6 no move", 32'({cmd_place, cmd_swap, cmd_discard}), 0);
      tbl_deny = 1;
      step();
      chk("R6 discard", 32'(cmd_discard), 1);
      chk("R6 discard way", 32'(cmd_way), 2);
      chk("R6 code discard", 32'({out_valid, out_code}), 32'h6);
      chk("R7 updb", 32'(upd_b_entries), 1);
      chk("R6 no upd d", 32'(upd_d_entries), 0);
      @(negedge clk); quiet(); xit_req_valid = 1; xit_req_id = 15;
      close_window("deny", 16'h8000);
   endtask

   task automatic t_unmigr_grant_tie();
      fire(0, 0, 11, 1, 0);
      chk("R6 req d again", 32'(tbl_req_d_home), 1);
      tbl_grant = 1; tbl_deny = 1;
      step();
      chk("R11 grant wins swap", 32'(cmd_swap), 1);
      chk("R11 not discard", 32'(cmd_discard), 0);
      chk("R6 grant way", 32'(cmd_way), 11);
      chk("R6 grant no upd d", 32'(upd_d_entries), 0);
      chk("R6 grant code", 32'({out_valid, out_code}), 32'h5);
      @(negedge clk); quiet();
      close_window("grant", '0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      quiet();
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1;
      step();
      t_reset();
      t_free_way();
      t_home_deny();
      t_migr_victim();
      t_unmigr_deny();
      t_unmigr_grant_tie();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule